// File: doc/BRIEF.md
# Stream Frame Writer with Completion Doorbell

This block takes one frame of 32-bit words from an AXI4-Stream input and stores it in memory through a simple word-write port. When the data is stored it writes one more word, the doorbell, which tells a consumer that the buffer is ready. The doorbell carries a sequence number, the number of words written and a flag that is set only when the frame had the requested length.

Software programs a base address, a data offset, a doorbell offset and a frame length in words through a small register port. It then writes the start bit. Each start runs the engine once, and the engine goes back to idle when the run ends. At the end of each run a packed status word is latched, and a status-valid flag is raised. Reading the flag clears it. A run requested with zero length writes nothing. It only completes and reports the largest supported frame length, which software uses to discover the engine's capacity.

Top module: `strm_frame_writer`

## Requirements
- R1: After reset the engine is idle: control bit 0 reads 0, the status-valid flag reads 0, and the status word (0x30) holds only the maximum frame length in bits 27:22. No memory write or stream beat is accepted until a start.
- R2: Data word i of a frame is written to base + data offset + 4*i, in stream order and with its value unchanged, whatever the stream gaps or memory back-pressure. A write request holds its address and data until it is accepted.
- R3: After the last data write has been accepted, exactly one doorbell word is written to base + doorbell offset. Its layout is: bits 15:0 the sequence number, bits 21:16 the count of data words written, bit 22 valid, and the upper bits zero.
- R4: A frame whose TLAST arrives exactly at the requested count sets doorbell bit 22. The sequence number starts at 0 after reset and rises by one after each such frame. The status word bits 15:0 and 21:16 show the sequence number and word count of the last run.
- R5: If TLAST arrives before the requested count, the engine stops after writing the words received. The doorbell then has bit 22 clear and the actual count. Status bit 29 is set, and the sequence number does not advance.
- R6: If the requested count is reached without TLAST, the rest of the frame is accepted up to TLAST and discarded without writes. The doorbell has bit 22 clear and count equal to the request. Status bit 30 is set.
- R7: A requested length of 0, or one above the maximum, sets status bit 28. It writes no data and no doorbell. The run still completes and sets the status-valid flag.
- R8: The status-valid flag (bit 0 of 0x34) is set when a run completes and is cleared by a read of 0x34.
- R9: A run is started by writing 1 to bit 0 of 0x00. While a run is active, control bit 0 and status bit 31 read 1. During a run, further start writes and writes to the configuration registers are ignored.
- R10: The configuration registers read back at base 0x10, data offset 0x18, doorbell offset 0x20 and frame length 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | Stream beat accepted |
| s_tdata_i | input | 32 | Stream data word |
| s_tlast_i | input | 1 | Last beat of the frame |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory write accepted |
| mem_addr_o | output | 32 | Memory byte address |
| mem_data_o | output | 32 | Memory write data |

## Verification
The assertions assume that the memory side follows valid/ready rules and that the register port is used only as the requirements describe. They do not assume that any frame arrives with the right length, so short, long and invalid runs are all legal stimulus. The bench drives every input half a cycle away from the active edge. Stream gaps and memory ready follow fixed, deterministic cycle patterns. All addresses stay inside a small window that the bench logs, and the bench does not change configuration except in the scenario that checks that such writes are ignored during a run.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_WRITE, S_DRAIN, S_BELL, S_FIN
  } eng_state_e;

  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_BASE = 6'h10;
  localparam logic [5:0] A_DOFF = 6'h18;
  localparam logic [5:0] A_BOFF = 6'h20;
  localparam logic [5:0] A_SIZE = 6'h28;
  localparam logic [5:0] A_STAT = 6'h30;
  localparam logic [5:0] A_SVLD = 6'h34;

  // bit 31 down to bit 0
  typedef struct packed {
    logic        running;
    logic        too_long;
    logic        too_short;
    logic        bad_size;
    logic [5:0]  max_words;
    logic [5:0]  count;
    logic [15:0] seq;
  } status_t;

  typedef struct packed {
    logic [8:0]  zero;
    logic        ok;
    logic [5:0]  count;
    logic [15:0] seq;
  } bell_t;
endpackage

// File: rtl/swr_regs.sv
module swr_regs
  import swr_pkg::*;
#(
  parameter int MAX_WORDS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        busy_i,
  input  logic        done_i,
  input  logic [15:0] res_seq_i,
  input  logic [5:0]  res_cnt_i,
  input  logic        res_bad_i,
  input  logic        res_short_i,
  input  logic        res_long_i,
  output logic        start_o,
  output logic [31:0] base_o,
  output logic [31:0] doff_o,
  output logic [31:0] boff_o,
  output logic [31:0] size_o,
  output logic        vld_o
);
  localparam logic [5:0] MAX6 = 6'(MAX_WORDS);

  logic        cfg_wr;
  logic [15:0] l_seq;
  logic [5:0]  l_cnt;
  logic        l_bad, l_short, l_long;
  status_t     stat;

  assign cfg_wr  = we_i && !busy_i;
  assign start_o = cfg_wr && addr_i == A_CTRL && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      doff_o <= '0;
      boff_o <= '0;
      size_o <= '0;
    end else if (cfg_wr) begin
      case (addr_i)
        A_BASE:  base_o <= wdata_i;
        A_DOFF:  doff_o <= wdata_i;
        A_BOFF:  boff_o <= wdata_i;
        A_SIZE:  size_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_seq   <= '0;
      l_cnt   <= '0;
      l_bad   <= 1'b0;
      l_short <= 1'b0;
      l_long  <= 1'b0;
      vld_o   <= 1'b0;
    end else begin
      if (done_i) begin
        l_seq   <= res_seq_i;
        l_cnt   <= res_cnt_i;
        l_bad   <= res_bad_i;
        l_short <= res_short_i;
        l_long  <= res_long_i;
      end
      // completion wins over a simultaneous clearing read
      if (done_i) vld_o <= 1'b1;
      else if (re_i && addr_i == A_SVLD) vld_o <= 1'b0;
    end
  end

  assign stat = '{running: busy_i, too_long: l_long, too_short: l_short,
                  bad_size: l_bad, max_words: MAX6, count: l_cnt, seq: l_seq};

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {31'b0, busy_i};
      A_BASE:  rdata_o = base_o;
      A_DOFF:  rdata_o = doff_o;
      A_BOFF:  rdata_o = boff_o;
      A_SIZE:  rdata_o = size_o;
      A_STAT:  rdata_o = stat;
      A_SVLD:  rdata_o = {31'b0, vld_o};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/swr_engine.sv
module swr_engine
  import swr_pkg::*;
#(
  parameter int MAX_WORDS = 32,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] base_i,
  input  logic [31:0] doff_i,
  input  logic [31:0] boff_i,
  input  logic [31:0] size_i,
  input  logic        s_tvalid_i,
  output logic        s_tready_o,
  input  logic [31:0] s_tdata_i,
  input  logic        s_tlast_i,
  output logic        mem_valid_o,
  input  logic        mem_ready_i,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_data_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] seq_o,
  output logic [5:0]  cnt_o,
  output logic        bad_o,
  output logic        short_o,
  output logic        long_o
);
  eng_state_e       state;
  logic [CNT_W-1:0] cnt, lim, cnt_nx;
  logic [31:0]      hold_data;
  logic             hold_last;
  logic [15:0]      seq;
  logic             size_ok;
  bell_t            bell;

  assign size_ok = size_i != '0 && size_i <= 32'(MAX_WORDS);
  assign cnt_nx  = cnt + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= S_IDLE;
      cnt       <= '0;
      lim       <= '0;
      hold_data <= '0;
      hold_last <= 1'b0;
      seq       <= '0;
      bad_o     <= 1'b0;
      short_o   <= 1'b0;
      long_o    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          cnt     <= '0;
          lim     <= size_i[CNT_W-1:0];
          bad_o   <= !size_ok;
          short_o <= 1'b0;
          long_o  <= 1'b0;
          state   <= size_ok ? S_RECV : S_FIN;
        end
        S_RECV: if (s_tvalid_i) begin
          hold_data <= s_tdata_i;
          hold_last <= s_tlast_i;
          state     <= S_WRITE;
        end
        S_WRITE: if (mem_ready_i) begin
          cnt <= cnt_nx;
          if (hold_last) begin
            short_o <= cnt_nx != lim;
            state   <= S_BELL;
          end else if (cnt_nx == lim) begin
            long_o <= 1'b1;
            state  <= S_DRAIN;
          end else begin
            state <= S_RECV;
          end
        end
        S_DRAIN: if (s_tvalid_i && s_tlast_i) state <= S_BELL;
        S_BELL:  if (mem_ready_i) state <= S_FIN;
        S_FIN: begin
          if (!bad_o && !short_o && !long_o) seq <= seq + 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bell = '{zero: '0, ok: !short_o && !long_o, count: 6'(cnt), seq: seq};

  assign s_tready_o  = state == S_RECV || state == S_DRAIN;
  assign mem_valid_o = state == S_WRITE || state == S_BELL;
  assign mem_addr_o  = (state == S_BELL) ? base_i + boff_i
                                         : base_i + doff_i + (32'(cnt) << 2);
  assign mem_data_o  = (state == S_BELL) ? bell : hold_data;
  assign busy_o      = state != S_IDLE;
  assign done_o      = state == S_FIN;
  assign seq_o       = seq;
  assign cnt_o       = 6'(cnt);
endmodule

// File: rtl/strm_frame_writer.sv
module strm_frame_writer #(
  parameter int MAX_WORDS = 32  // 1..63, reported in a 6-bit field
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        s_tvalid_i,
  output logic        s_tready_o,
  input  logic [31:0] s_tdata_i,
  input  logic        s_tlast_i,
  output logic        mem_valid_o,
  input  logic        mem_ready_i,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_data_o
);
  logic        start_w, busy_w, done_w, vld_w;
  logic        bad_w, short_w, long_w;
  logic [15:0] seq_w;
  logic [5:0]  cnt_w;
  logic [31:0] base_w, doff_w, boff_w, size_w;

  swr_regs #(.MAX_WORDS(MAX_WORDS)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_w), .done_i(done_w),
    .res_seq_i(seq_w), .res_cnt_i(cnt_w), .res_bad_i(bad_w),
    .res_short_i(short_w), .res_long_i(long_w),
    .start_o(start_w), .base_o(base_w), .doff_o(doff_w),
    .boff_o(boff_w), .size_o(size_w), .vld_o(vld_w)
  );

  swr_engine #(.MAX_WORDS(MAX_WORDS)) i_engine (
    .clk_i, .rst_ni,
    .start_i(start_w), .base_i(base_w), .doff_i(doff_w),
    .boff_i(boff_w), .size_i(size_w),
    .s_tvalid_i, .s_tready_o, .s_tdata_i, .s_tlast_i,
    .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_data_o,
    .busy_o(busy_w), .done_o(done_w), .seq_o(seq_w), .cnt_o(cnt_w),
    .bad_o(bad_w), .short_o(short_w), .long_o(long_w)
  );
endmodule

// File: rtl/swr_checker.sv
module swr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy,
  input logic        done,
  input logic        bad,
  input logic        status_vld,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_data,
  input logic        s_tready
);
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_valid && !s_tready);

  a_r9_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done |=> busy);

  a_r8_vld_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> status_vld);

  a_r7_bad_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && bad |-> !mem_valid && !s_tready);
endmodule

bind strm_frame_writer swr_checker i_swr_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy_w), .done(done_w), .bad(bad_w),
  .status_vld(vld_w), .mem_valid(mem_valid_o), .mem_ready(mem_ready_i),
  .mem_addr(mem_addr_o), .mem_data(mem_data_o), .s_tready(s_tready_o)
);

// File: tb/test_strm_frame_writer.sv
module test_strm_frame_writer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 32;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        s_tvalid_i = 1'b0, s_tready_o, s_tlast_i = 1'b0;
  logic [31:0] s_tdata_i = '0;
  logic        mem_valid_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_data_o;

  strm_frame_writer #(.MAX_WORDS(MAXW)) i_strm_frame_writer (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // stream source and memory sink, all at the falling edge
  logic [31:0] beats [16];
  bit          lasts [16];
  int          nbeats = 0, idx = 0;
  bit          src_en = 1, gaps = 0, bp = 0;
  logic [31:0] wr_addr [32];
  logic [31:0] wr_data [32];
  int          wr_n = 0;

  always @(negedge clk_i) begin
    cyc++;
    mem_ready_i = bp ? (cyc % 2 == 0) : 1'b1;
    if (mem_valid_o && mem_ready_i && wr_n < 32) begin
      wr_addr[wr_n] = mem_addr_o;
      wr_data[wr_n] = mem_data_o;
      wr_n++;
    end
    s_tvalid_i = src_en && idx < nbeats && !(gaps && cyc % 3 == 0);
    s_tdata_i  = (idx < nbeats) ? beats[idx] : 32'h0;
    s_tlast_i  = (idx < nbeats) ? lasts[idx] : 1'b0;
    if (s_tvalid_i && s_tready_o) idx++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic load(input int n, input int last_at, input logic [31:0] seed);
    for (int i = 0; i < 16; i++) begin
      beats[i] = seed + 32'(i) * 32'h01010101;
      lasts[i] = (i == last_at);
    end
    nbeats = n; idx = 0; wr_n = 0;
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] doff,
                       input logic [31:0] boff, input logic [31:0] size);
    wr(6'h10, base); wr(6'h18, doff); wr(6'h20, boff); wr(6'h28, size);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(6'h00, v);
      if (!v[0]) break;
    end
  endtask

  task automatic run(input string req, input logic [31:0] exp_stat);
    logic [31:0] v;
    wr(6'h00, 32'h1);
    wait_idle();
    rd(6'h34, v); chk({req, " R8 valid set"}, v, 32'h1);
    rd(6'h34, v); chk({req, " R8 valid cleared by read"}, v, 32'h0);
    rd(6'h30, v); chk({req, " status"}, v, exp_stat);
  endtask

  task automatic chk_data(input string req, input int n, input logic [31:0] a0,
                          input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      chk({req, " addr"}, wr_addr[i], a0 + 32'(i) * 4);
      chk({req, " data"}, wr_data[i], seed + 32'(i) * 32'h01010101);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h00, v); chk("R1 ctrl idle", v, 32'h0);
    rd(6'h34, v); chk("R1 valid flag", v, 32'h0);
    rd(6'h30, v); chk("R1 status", v, 32'h0800_0000);
    chk("R1 no writes", 32'(wr_n), 32'h0);
  endtask

  task automatic t_exact16();
    logic [31:0] v;
    load(16, 15, 32'hA000_0000);
    setup(32'h100, 32'h0, 32'h40, 32'd16);
    rd(6'h10, v); chk("R10 base", v, 32'h100);
    rd(6'h18, v); chk("R10 data offset", v, 32'h0);
    rd(6'h20, v); chk("R10 doorbell offset", v, 32'h40);
    rd(6'h28, v); chk("R10 size", v, 32'd16);
    run("R4 exact16", 32'h0810_0000);
    chk("R3 write count", 32'(wr_n), 32'd17);
    chk_data("R2 exact16", 16, 32'h100, 32'hA000_0000);
    chk("R3 bell addr", wr_addr[16], 32'h140);
    chk("R3 R4 bell word", wr_data[16], 32'h0050_0000);
  endtask

  task automatic t_backpressure();
    load(10, 9, 32'h1234_0000);
    gaps = 1; bp = 1;
    setup(32'h200, 32'h40, 32'h0, 32'd10);
    run("R4 seq1", 32'h080A_0001);
    gaps = 0; bp = 0;
    chk("R3 write count bp", 32'(wr_n), 32'd11);
    chk_data("R2 backpressure", 10, 32'h240, 32'h1234_0000);
    chk("R3 bell addr bp", wr_addr[10], 32'h200);
    chk("R4 bell seq1", wr_data[10], 32'h004A_0001);
  endtask

  task automatic t_short();
    load(5, 4, 32'h5500_0000);
    setup(32'h300, 32'h0, 32'h80, 32'd8);
    run("R5 short", 32'h2805_0002);
    chk("R5 write count", 32'(wr_n), 32'd6);
    chk_data("R5 short", 5, 32'h300, 32'h5500_0000);
    chk("R5 bell addr", wr_addr[5], 32'h380);
    chk("R5 bell word", wr_data[5], 32'h0005_0002);
  endtask

  task automatic t_long();
    load(7, 6, 32'h7700_0000);
    setup(32'h400, 32'h0, 32'h10, 32'd4);
    run("R6 long", 32'h4804_0002);
    chk("R6 write count", 32'(wr_n), 32'd5);
    chk_data("R6 long", 4, 32'h400, 32'h7700_0000);
    chk("R6 bell addr", wr_addr[4], 32'h410);
    chk("R6 bell word", wr_data[4], 32'h0004_0002);
    chk("R6 drained all beats", 32'(idx), 32'd7);
  endtask

  task automatic t_invalid();
    load(0, 0, 32'h0);
    setup(32'h600, 32'h0, 32'h0, 32'd0);
    run("R7 zero size", 32'h1800_0002);
    chk("R7 zero size no writes", 32'(wr_n), 32'h0);
    load(0, 0, 32'h0);
    wr(6'h28, 32'(MAXW + 1));
    run("R7 oversize", 32'h1800_0002);
    chk("R7 oversize no writes", 32'(wr_n), 32'h0);
  endtask

  task automatic t_one_shot();
    logic [31:0] v;
    load(4, 3, 32'h9900_0000);
    src_en = 0;
    setup(32'h500, 32'h0, 32'h10, 32'd4);
    wr(6'h00, 32'h1);
    rd(6'h00, v); chk("R9 ctrl busy", v, 32'h1);
    rd(6'h30, v); chk("R9 running bit", v & 32'h8000_0000, 32'h8000_0000);
    wr(6'h28, 32'd9);
    rd(6'h28, v); chk("R9 size write ignored", v, 32'd4);
    wr(6'h00, 32'h1);
    src_en = 1;
    wait_idle();
    rd(6'h34, v); chk("R9 R8 valid", v, 32'h1);
    rd(6'h30, v); chk("R9 status", v, 32'h0804_0002);
    chk("R9 single run writes", 32'(wr_n), 32'd5);
    chk("R9 bell word", wr_data[4], 32'h0044_0002);
    rd(6'h00, v); chk("R9 idle after run", v, 32'h0);
    load(1, 0, 32'hBEEF_0000);
    wr(6'h28, 32'd1);
    run("R4 seq3", 32'h0801_0003);
    chk("R4 bell seq3", wr_data[1], 32'h0041_0003);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_exact16();
    t_backpressure();
    t_short();
    t_long();
    t_invalid();
    t_one_shot();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule